// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

The block gathers 18 interrupt request lines and hands a small CPU core a single request together with the index of the winning source. The sources are arranged in six groups of three. Source `s` belongs to group `s mod 6`. Software gives each group one of four priority levels, and every source in the group takes that level. A rising edge on a request line sets a pending flag. Among the enabled pending sources, the arbiter chooses the one with the highest level. A tie goes to the lowest group number, and a tie inside a group goes to the lowest source number.

The block forwards a winner only when its level is strictly above the level the CPU is currently serving. A small stack records each level the CPU has accepted, so nested service can go four deep. An acknowledge pulse pushes the accepted level and clears that source's pending flag. A return pulse pops the stack. While the sleep input is high, no request goes to the CPU. Instead, the designated wake-capable sources drive a wake output so that power management can bring the core back, after which the request is serviced normally.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After synchronous reset: `cpu_irq` and `wake` are 0, the enable (addr 0), priority-low (addr 2), priority-high (addr 3), control (addr 4) and nesting (addr 5) registers read 0, and all groups are at level 0.
- R2: A pending flag is set only in the cycle after a 0-to-1 change of its request line. A request held high does not set the flag again once it has been cleared.
- R3: A write to the pending register (addr 1) clears every flag whose data bit is 0. Data bits of 1 leave their flags unchanged and never set a flag. Reading addr 1 returns the pending flags.
- R4: The level of group g is {prio_hi[g], prio_lo[g]}, held at addr 3 (bit 1 of the level) and addr 2 (bit 0). Source s takes the level of group s mod 6.
- R5: Among pending sources whose enable bit (addr 0, bit s) is set, the highest level wins. On a tie the lowest group number wins, and within one group the lowest source number wins. The winner appears on `cpu_vec`.
- R6: `cpu_irq` is raised only when all of the following hold: a winner exists, control bit 0 (global enable) is 1, `sleep` is 0, and either the nesting stack is empty or the winner's level is strictly above the top of the stack.
- R7: When `cpu_ack` is high while `cpu_irq` is high, the block clears the pending flag of `cpu_vec`, pushes its level onto the stack, and holds `cpu_irq` at 0 in the following cycle. An acknowledge while `cpu_irq` is low is ignored.
- R8: A `cpu_ret` pulse pops one stack entry. A pulse on an empty stack is ignored. Addr 5 reads the top level in bits [1:0] and the depth (0 to 4) in bits [4:2].
- R9: While `sleep` is high, `wake` is 1 one cycle after any enabled pending source in the wake set (sources 3 and 4 by default). The global enable has no effect on `wake`. Other sources never raise `wake`, and `wake` is 0 while `sleep` is low.
- R10: Register reads are registered: `reg_rdata` shows the register selected by `reg_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 18 | Request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 18 | Write data |
| reg_rdata | output | 18 | Registered read data |
| cpu_irq | output | 1 | Request to the CPU |
| cpu_vec | output | 5 | Index of the winning source |
| cpu_ack | input | 1 | CPU accepts the offered vector |
| cpu_ret | input | 1 | CPU leaves the current handler |
| sleep | input | 1 | Device is in a sleep state |
| wake | output | 1 | Wake request to power management |

## Verification
The bench builds the block with its default parameters: 18 sources, six groups of three, 2-bit levels, a 4-deep stack and a wake set of sources 3 and 4. With a 4-deep stack the bench can walk the nesting through real levels and back, including a return on an empty stack. With three sources per group, every tie-break case is reachable: a tie across groups, a tie inside one group, and a priority win by a higher-numbered source. The wake set is small, so the bench can compare a wake source against an ordinary source while the global enable is off.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE  = 3'd0,
    RA_PEND    = 3'd1,
    RA_PRIO_LO = 3'd2,
    RA_PRIO_HI = 3'd3,
    RA_CTRL    = 3'd4,
    RA_NEST    = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/grp_irq_src_bank.sv
// Edge capture and pending flags for all request lines.
module grp_irq_src_bank #(
  parameter int unsigned N_SRC = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  input  logic             sw_we,
  input  logic [N_SRC-1:0] sw_keep,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      // a fresh edge in the same cycle as a clear keeps the flag set
      pend  <= ((sw_we ? (pend & sw_keep) : pend) & ~ack_clr) | rise;
    end
  end
endmodule

// File: rtl/grp_irq_arbiter.sv
// Combinational winner selection: level, then group, then source.
module grp_irq_arbiter #(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned N_GRP = 6,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned SPG   = N_SRC / N_GRP,
  localparam int unsigned VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] cand,
  input  logic [N_GRP-1:0] prio_lo,
  input  logic [N_GRP-1:0] prio_hi,
  output logic             hit,
  output logic [VEC_W-1:0] win_idx,
  output logic [LVL_W-1:0] win_lvl
);
  logic [LVL_W-1:0] src_lvl [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
    assign src_lvl[s] = LVL_W'({prio_hi[s % N_GRP], prio_lo[s % N_GRP]});
  end

  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int g = 0; g < N_GRP; g++) begin
      for (int k = 0; k < SPG; k++) begin
        if (cand[g + k*N_GRP] && (!hit || src_lvl[g + k*N_GRP] > win_lvl)) begin
          hit     = 1'b1;
          win_idx = VEC_W'(g + k*N_GRP);
          win_lvl = src_lvl[g + k*N_GRP];
        end
      end
    end
  end
endmodule

// File: rtl/grp_irq_nest.sv
// Stack of levels currently in service.
module grp_irq_nest #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [CNT_W-1:0] depth,
  output logic [LVL_W-1:0] top,
  output logic             empty
);
  logic [LVL_W-1:0] stk [DEPTH];

  assign empty = (depth == '0);
  assign top   = empty ? '0 : stk[IDX_W'(depth - 1'b1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
    end else if (push) begin
      if (depth < CNT_W'(DEPTH)) begin
        stk[IDX_W'(depth)] <= push_lvl;
        depth              <= depth + 1'b1;
      end
    end else if (pop && !empty) begin
      depth <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int unsigned      N_SRC    = 18,
  parameter int unsigned      N_GRP    = 6,
  parameter int unsigned      LVL_W    = 2,
  parameter int unsigned      DEPTH    = 4,
  parameter logic [N_SRC-1:0] WAKE_SRC = 18'h00018,
  localparam int unsigned     VEC_W    = $clog2(N_SRC),
  localparam int unsigned     CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              cpu_irq,
  output logic [VEC_W-1:0]  cpu_vec,
  input  logic              cpu_ack,
  input  logic              cpu_ret,
  input  logic              sleep,
  output logic              wake
);
  logic [N_SRC-1:0] en_q;
  logic [N_GRP-1:0] prio_lo_q, prio_hi_q;
  logic             glb_q;
  logic [LVL_W-1:0] cpu_lvl_q;

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] ack_clr;
  logic             take;
  logic             hit;
  logic [VEC_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic [CNT_W-1:0] depth;
  logic [LVL_W-1:0] top;
  logic             empty;
  logic             fwd;

  assign take    = cpu_ack & cpu_irq;
  assign ack_clr = take ? (N_SRC'(1) << cpu_vec) : '0;

  grp_irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .req     (irq_req),
    .sw_we   (reg_we && reg_addr == RA_PEND),
    .sw_keep (reg_wdata),
    .ack_clr (ack_clr),
    .pend    (pend)
  );

  grp_irq_arbiter #(.N_SRC(N_SRC), .N_GRP(N_GRP), .LVL_W(LVL_W)) u_arb (
    .cand    (pend & en_q),
    .prio_lo (prio_lo_q),
    .prio_hi (prio_hi_q),
    .hit     (hit),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  grp_irq_nest #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_nest (
    .clk      (clk),
    .rst      (rst),
    .push     (take),
    .push_lvl (cpu_lvl_q),
    .pop      (cpu_ret),
    .depth    (depth),
    .top      (top),
    .empty    (empty)
  );

  assign fwd = hit && glb_q && !sleep && (empty || win_lvl > top);

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      prio_lo_q <= '0;
      prio_hi_q <= '0;
      glb_q     <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_ENABLE:  en_q      <= reg_wdata;
        RA_PRIO_LO: prio_lo_q <= N_GRP'(reg_wdata);
        RA_PRIO_HI: prio_hi_q <= N_GRP'(reg_wdata);
        RA_CTRL:    glb_q     <= 1'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_ENABLE:  reg_rdata <= en_q;
        RA_PEND:    reg_rdata <= pend;
        RA_PRIO_LO: reg_rdata <= N_SRC'(prio_lo_q);
        RA_PRIO_HI: reg_rdata <= N_SRC'(prio_hi_q);
        RA_CTRL:    reg_rdata <= N_SRC'(glb_q);
        RA_NEST:    reg_rdata <= N_SRC'({depth, top});
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // CPU-facing and wake outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      cpu_vec   <= '0;
      cpu_lvl_q <= '0;
      wake      <= 1'b0;
    end else begin
      cpu_irq <= take ? 1'b0 : fwd;
      if (!take) begin
        cpu_vec   <= win_idx;
        cpu_lvl_q <= win_lvl;
      end
      wake <= sleep && |(pend & en_q & WAKE_SRC);
    end
  end
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned VEC_W = 5,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_irq,
  input logic [VEC_W-1:0] cpu_vec,
  input logic             cpu_ack,
  input logic             sleep,
  input logic             wake,
  input logic             glb_en,
  input logic [N_SRC-1:0] pend,
  input logic [CNT_W-1:0] depth,
  input logic [LVL_W-1:0] top,
  input logic [LVL_W-1:0] cpu_lvl
);
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> ($past(glb_en) && !$past(sleep)));

  assert_strict_level_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (depth == '0 || cpu_lvl > top));

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_irq) |=> !cpu_irq);

  assert_vec_pending_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> ((($past(pend) >> cpu_vec) & N_SRC'(1)) != '0));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));

  assert_wake_in_sleep_R9: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(sleep));
endmodule

bind grp_irq_ctrl grp_irq_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack),
  .sleep(sleep), .wake(wake), .glb_en(glb_q), .pend(pend), .depth(depth),
  .top(top), .cpu_lvl(cpu_lvl_q)
);

// File: tb/grp_irq_ctrl_tb.sv
module grp_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  localparam logic [17:0] V_REQ [NV] = '{18'h00082, 18'h02004, 18'h20021,
                                         18'h01040, 18'h00300, 18'h04008};
  localparam logic [5:0]  V_LO  [NV] = '{6'h00, 6'h02, 6'h01, 6'h00, 6'h3F, 6'h04};
  localparam logic [5:0]  V_HI  [NV] = '{6'h00, 6'h02, 6'h20, 6'h00, 6'h00, 6'h08};
  localparam int          V_EXP [NV] = '{1, 13, 5, 6, 8, 3};

  logic        clk = 0;
  logic        rst = 1;
  logic [17:0] irq_req = '0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [17:0] reg_wdata = '0;
  logic [17:0] reg_rdata;
  logic        cpu_irq;
  logic [4:0]  cpu_vec;
  logic        cpu_ack = 0;
  logic        cpu_ret = 0;
  logic        sleep = 0;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
    .cpu_ack(cpu_ack), .cpu_ret(cpu_ret), .sleep(sleep), .wake(wake)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [17:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    reg_addr = a;
    tick();
    v = int'(reg_rdata);
  endtask

  task automatic pulse(logic [17:0] p);
    irq_req = p;
    tick();
    irq_req = '0;
    tick();
  endtask

  task automatic ack();
    cpu_ack = 1;
    tick();
    cpu_ack = 0;
  endtask

  task automatic ret();
    cpu_ret = 1;
    tick();
    cpu_ret = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int v;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1 irq", int'(cpu_irq), 0);
    check("R1 wake", int'(wake), 0);
    rd(3'd0, v); check("R1 enable", v, 0);
    rd(3'd2, v); check("R1 prio_lo", v, 0);
    rd(3'd3, v); check("R1 prio_hi", v, 0);
    rd(3'd4, v); check("R1 ctrl", v, 0);
    rd(3'd5, v); check("R1 nest", v, 0);

    wr(3'd0, 18'h3FFFF);
    wr(3'd4, 18'h00001);
    rd(3'd0, v); check("R10 enable readback", v, 'h3FFFF);

    // R4 R5 arbitration vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd2, 18'(V_LO[i]));
      wr(3'd3, 18'(V_HI[i]));
      pulse(V_REQ[i]);
      check("R5 irq", int'(cpu_irq), 1);
      check("R4 R5 vec", int'(cpu_vec), V_EXP[i]);
      wr(3'd1, 18'h0);
      tick();
    end

    // R2 held request does not re-pend; R3 clear by write
    wr(3'd2, 18'h0); wr(3'd3, 18'h0);
    irq_req = 18'h00400;
    tick(); tick();
    rd(3'd1, v); check("R2 pend set", v, 'h00400);
    wr(3'd1, ~18'h00400);
    tick(); tick();
    rd(3'd1, v); check("R2 held no repend", v, 0);
    irq_req = '0;
    tick();
    wr(3'd1, 18'h3FFFF);
    rd(3'd1, v); check("R3 write one ignored", v, 0);

    // R6 R7 R8 nesting: group1 lvl1, group2 lvl2
    wr(3'd2, 18'h02); wr(3'd3, 18'h04);
    pulse(18'h00002);
    check("R7 irq src1", int'(cpu_irq), 1);
    check("R7 vec src1", int'(cpu_vec), 1);
    ack();
    check("R7 irq drops", int'(cpu_irq), 0);
    rd(3'd1, v); check("R7 pend cleared", v, 0);
    rd(3'd5, v); check("R8 nest depth1", v, 5);
    pulse(18'h00080);
    check("R6 equal level held", int'(cpu_irq), 0);
    pulse(18'h00004);
    check("R6 higher level forwarded", int'(cpu_irq), 1);
    check("R6 vec src2", int'(cpu_vec), 2);
    ack();
    rd(3'd5, v); check("R8 nest depth2", v, 10);
    ret();
    rd(3'd5, v); check("R8 pop", v, 5);
    check("R6 still blocked", int'(cpu_irq), 0);
    ret();
    tick();
    check("R8 after pop irq", int'(cpu_irq), 1);
    check("R8 after pop vec", int'(cpu_vec), 7);
    ack();
    ret();
    rd(3'd5, v); check("R8 empty", v, 0);
    ret();
    rd(3'd5, v); check("R8 pop on empty ignored", v, 0);
    ack();
    rd(3'd5, v); check("R7 ack ignored when idle", v, 0);

    // R6 R9 global enable, sleep, wake
    wr(3'd4, 18'h0);
    pulse(18'h00008);
    check("R6 global off", int'(cpu_irq), 0);
    check("R9 awake no wake", int'(wake), 0);
    sleep = 1;
    tick();
    check("R9 wake source", int'(wake), 1);
    check("R6 sleep no irq", int'(cpu_irq), 0);
    sleep = 0;
    wr(3'd4, 18'h1);
    tick();
    check("R6 enabled irq", int'(cpu_irq), 1);
    check("R6 vec src3", int'(cpu_vec), 3);
    sleep = 1;
    tick();
    check("R6 sleep masks", int'(cpu_irq), 0);
    wr(3'd1, 18'h0);
    pulse(18'h00001);
    check("R9 non-wake source", int'(wake), 0);
    sleep = 0;
    tick();
    check("R9 wake low awake", int'(wake), 0);
    check("R6 resume src0", int'(cpu_vec), 0);
    check("R6 resume irq", int'(cpu_irq), 1);

    finish_run();
  end
endmodule